// File: doc/BRIEF.md
# BLAKE2b Round Mixing Unit

This unit applies one complete BLAKE2b compression round to a working state of sixteen 64-bit words. A caller presents the current state, the sixteen 64-bit words of the message block and a round index, then raises `start` for one cycle. The new state is registered and `done` pulses in the next cycle. The output register keeps its value until the next start. This lets a sequencer outside the block feed the result back in for twelve rounds in a row.

Inside the round there are two passes, and each pass runs four quarter-round mixes at the same time. The column pass works first. The diagonal pass then works on the column results. The round index selects one of ten fixed message permutations, and each mix draws its two message words through that permutation. Padding, the byte counter, the chaining value and the control of multi-block messages are all handled outside this unit.

Top module: `b2b_round_unit`

## Requirements
- R1: While `rstN` is low at a clock edge, `done` is 0 after that edge and `stateOut` is all zero.
- R2: `done` is 1 in the cycle that follows every edge at which `start` was 1, and 0 after every edge at which `start` was 0.
- R3: When `start` is 0, `stateOut` keeps its previous value, whatever `stateIn`, `msgIn` and `roundIdx` do.
- R4: Each mix on (a,b,c,d) with message words x and y performs these steps in order: a=a+b+x, d=rotr(d^a,32), c=c+d, b=rotr(b^c,24), a=a+b+y, d=rotr(d^a,16), c=c+d, b=rotr(b^c,63). The rotations are 64-bit right rotations. An all-zero state and message therefore give an all-zero result.
- R5: The column pass applies mix groups 0..3 to word sets (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15).
- R6: The diagonal pass applies mix groups 4..7 to word sets (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). It uses the values that the column pass produced.
- R7: Mix group g uses x = m[s[2g]] and y = m[s[2g+1]], where s is the selected permutation row. State word j is `stateIn[64*j+:64]` and message word k is `msgIn[64*k+:64]`, and `stateOut` uses the same packing as `stateIn`.
- R8: The permutation row is `roundIdx` mod 10. Rounds 10 and 11 reuse rows 0 and 1, and index values 12..15 map to rows 2..5.
- R9: Every addition wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Compute one round on the present inputs |
| roundIdx | input | 4 | Round number; selects the permutation row |
| stateIn | input | 1024 | Working state, 16 words of 64 bits, word 0 in the low bits |
| msgIn | input | 1024 | Message block, 16 words of 64 bits, word 0 in the low bits |
| done | output | 1 | One-cycle pulse when `stateOut` holds a new round result |
| stateOut | output | 1024 | Registered round result |

## Verification
The hardest thing to observe is the message routing. When every message word is dense, a wrong permutation entry shows up only as an unexplained change somewhere in 1024 bits, and two rows can look alike. For that reason the stimulus sweeps every round index, including the unused values 12..15, against a message that is zero except for a single word. This exposes which mix group takes that word and whether it enters as x or as y. Dense random messages, an all-ones state that forces the additions to wrap, and input changes while `start` is low complete the sweep.

// File: rtl/b2b_pkg.sv
package b2b_pkg;
  localparam int WORD_W    = 64;
  localparam int NUM_WORDS = 16;
  localparam int ROUND_W   = 4;
  localparam int NUM_ROWS  = 10;
  localparam int NIB_W     = $clog2(NUM_WORDS);
  localparam int BLOCK_W   = WORD_W * NUM_WORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NUM_WORDS-1:0] block_t;
  typedef logic [ROUND_W-1:0] round_t;

  typedef struct packed {
    logic loadOut;
  } ctrl_t;

  // Right rotation of one word by a fixed amount.
  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  // Each row packs 16 message indices, entry i sitting in nibble i.
  function automatic logic [NUM_WORDS*NIB_W-1:0] permRow(round_t row);
    case (row)
      4'd0: return 64'hFEDCBA9876543210;
      4'd1: return 64'h357B20C16DF984AE;
      4'd2: return 64'h491763EADF250C8B;
      4'd3: return 64'h8F04A562EBCD1397;
      4'd4: return 64'hD386CB1EFA427509;
      4'd5: return 64'h91EF57D438B0A6C2;
      4'd6: return 64'hB8293670A4DEF15C;
      4'd7: return 64'hA2684F05931CE7BD;
      4'd8: return 64'h5A417D2C803B9EF6;
      4'd9: return 64'h0DC3E9BF5167482A;
      default: return 64'hFEDCBA9876543210;
    endcase
  endfunction
endpackage

// File: rtl/b2b_mix.sv
module b2b_mix
  import b2b_pkg::*;
(
  input  word_t aIn,
  input  word_t bIn,
  input  word_t cIn,
  input  word_t dIn,
  input  word_t mx,
  input  word_t my,
  output word_t aOut,
  output word_t bOut,
  output word_t cOut,
  output word_t dOut
);
  word_t a1, d1, c1, b1, a2, d2, c2;

  always_comb begin
    a1 = aIn + bIn + mx;
    d1 = rotr(dIn ^ a1, 32);
    c1 = cIn + d1;
    b1 = rotr(bIn ^ c1, 24);
    a2 = a1 + b1 + my;
    d2 = rotr(d1 ^ a2, 16);
    c2 = c1 + d2;
    aOut = a2;
    dOut = d2;
    cOut = c2;
    bOut = rotr(b1 ^ c2, 63);
  end
endmodule

// File: rtl/b2b_round_ctrl.sv
module b2b_round_ctrl
  import b2b_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  output ctrl_t ctrl,
  output logic  done
);
  always_comb ctrl.loadOut = start;

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end
endmodule

// File: rtl/b2b_round_dp.sv
module b2b_round_dp
  import b2b_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  ctrl_t  ctrl,
  input  round_t roundIdx,
  input  block_t stateIn,
  input  block_t msgIn,
  output block_t stateOut
);
  localparam int GROUPS = NUM_WORDS / 4;

  round_t rowSel;
  logic [NUM_WORDS*NIB_W-1:0] perm;
  block_t colV, diagV;

  always_comb begin
    rowSel = (roundIdx >= round_t'(NUM_ROWS)) ? roundIdx - round_t'(NUM_ROWS) : roundIdx;
    perm   = permRow(rowSel);
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_col
    b2b_mix u_mix (
      .aIn (stateIn[g]),
      .bIn (stateIn[g + GROUPS]),
      .cIn (stateIn[g + 2*GROUPS]),
      .dIn (stateIn[g + 3*GROUPS]),
      .mx  (msgIn[perm[(2*g)*NIB_W +: NIB_W]]),
      .my  (msgIn[perm[(2*g+1)*NIB_W +: NIB_W]]),
      .aOut(colV[g]),
      .bOut(colV[g + GROUPS]),
      .cOut(colV[g + 2*GROUPS]),
      .dOut(colV[g + 3*GROUPS])
    );
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_diag
    localparam int BI = GROUPS   + (g + 1) % GROUPS;
    localparam int CI = 2*GROUPS + (g + 2) % GROUPS;
    localparam int DI = 3*GROUPS + (g + 3) % GROUPS;
    localparam int SX = 2*(g + GROUPS);
    b2b_mix u_mix (
      .aIn (colV[g]),
      .bIn (colV[BI]),
      .cIn (colV[CI]),
      .dIn (colV[DI]),
      .mx  (msgIn[perm[SX*NIB_W +: NIB_W]]),
      .my  (msgIn[perm[(SX+1)*NIB_W +: NIB_W]]),
      .aOut(diagV[g]),
      .bOut(diagV[BI]),
      .cOut(diagV[CI]),
      .dOut(diagV[DI])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)             stateOut <= '0;
    else if (ctrl.loadOut) stateOut <= diagV;
  end
endmodule

// File: rtl/b2b_round_unit.sv
module b2b_round_unit
  import b2b_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ROUND_W-1:0]   roundIdx,
  input  logic [BLOCK_W-1:0]   stateIn,
  input  logic [BLOCK_W-1:0]   msgIn,
  output logic                 done,
  output logic [BLOCK_W-1:0]   stateOut
);
  ctrl_t  ctrl;
  block_t stateOutW;

  b2b_round_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrl),
    .done (done)
  );

  b2b_round_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .roundIdx(roundIdx),
    .stateIn (block_t'(stateIn)),
    .msgIn   (block_t'(msgIn)),
    .stateOut(stateOutW)
  );

  assign stateOut = stateOutW;
endmodule

// File: rtl/b2b_round_chk.sv
module b2b_round_chk
  import b2b_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [BLOCK_W-1:0] stateIn,
  input logic [BLOCK_W-1:0] msgIn,
  input logic               done,
  input logic [BLOCK_W-1:0] stateOut
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done); // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(stateOut)); // R3
  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (start && stateIn == '0 && msgIn == '0) |=> stateOut == '0); // R4
endmodule

bind b2b_round_unit b2b_round_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .stateIn (stateIn),
  .msgIn   (msgIn),
  .done    (done),
  .stateOut(stateOut)
);

// File: tb/b2b_round_unit_bench.sv
module b2b_round_unit_bench;
  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    roundIdx = '0;
  logic [1023:0] stateIn = '0;
  logic [1023:0] msgIn = '0;
  logic          done;
  logic [1023:0] stateOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [63:0] seed = 64'h0123_4567_89AB_CDEF;
  logic [63:0] mv [16];
  logic [63:0] mm [16];

  always #5 clk = ~clk;

  b2b_round_unit u_b2b_round_unit (
    .clk(clk), .rstN(rstN), .start(start), .roundIdx(roundIdx),
    .stateIn(stateIn), .msgIn(msgIn), .done(done), .stateOut(stateOut)
  );

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [63:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic logic [63:0] rr(logic [63:0] x, int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  // Permutation index from the requirements (R7, R8): entry p of row r.
  function automatic int permIdx(int r, int p);
    logic [63:0] rows [10];
    rows[0] = 64'hFEDCBA9876543210; rows[1] = 64'h357B20C16DF984AE;
    rows[2] = 64'h491763EADF250C8B; rows[3] = 64'h8F04A562EBCD1397;
    rows[4] = 64'hD386CB1EFA427509; rows[5] = 64'h91EF57D438B0A6C2;
    rows[6] = 64'hB8293670A4DEF15C; rows[7] = 64'hA2684F05931CE7BD;
    rows[8] = 64'h5A417D2C803B9EF6; rows[9] = 64'h0DC3E9BF5167482A;
    return int'(rows[r % 10][p*4 +: 4]);
  endfunction

  // R4 mix applied to the model state mv.
  function automatic void gMix(int a, int b, int c, int d, logic [63:0] x, logic [63:0] y);
    mv[a] = mv[a] + mv[b] + x;  mv[d] = rr(mv[d] ^ mv[a], 32);
    mv[c] = mv[c] + mv[d];      mv[b] = rr(mv[b] ^ mv[c], 24);
    mv[a] = mv[a] + mv[b] + y;  mv[d] = rr(mv[d] ^ mv[a], 16);
    mv[c] = mv[c] + mv[d];      mv[b] = rr(mv[b] ^ mv[c], 63);
  endfunction

  function automatic logic [1023:0] model(int r);
    logic [1023:0] res;
    for (int i = 0; i < 16; i++) begin
      mv[i] = stateIn[64*i +: 64];
      mm[i] = msgIn[64*i +: 64];
    end
    for (int g = 0; g < 4; g++)   // R5 columns
      gMix(g, g+4, g+8, g+12, mm[permIdx(r, 2*g)], mm[permIdx(r, 2*g+1)]);
    for (int g = 0; g < 4; g++)   // R6 diagonals
      gMix(g, 4+(g+1)%4, 8+(g+2)%4, 12+(g+3)%4,
           mm[permIdx(r, 8+2*g)], mm[permIdx(r, 9+2*g)]);
    for (int i = 0; i < 16; i++) res[64*i +: 64] = mv[i];
    return res;
  endfunction

  task automatic runCase(string tag);
    logic [1023:0] exp;
    logic [1023:0] held;
    exp = model(int'(roundIdx));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (done !== 1'b1) begin
      fails++;
      $display("FAIL R2 %s: done actual %b expected 1", tag, done);
    end
    checks++;
    if (stateOut !== exp) begin
      fails++;
      $display("FAIL %s round %0d: stateOut actual %h expected %h", tag, roundIdx, stateOut, exp);
    end
    held = stateOut;
    stateIn = ~stateIn;
    msgIn = {msgIn[511:0], msgIn[1023:512]} ^ 1024'h5;
    roundIdx = roundIdx + 4'd3;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || stateOut !== held) begin
      fails++;
      $display("FAIL R3 %s: done %b stateOut %h expected done 0 stateOut %h", tag, done, stateOut, held);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;   // R1 reset state
    if (done !== 1'b0 || stateOut !== '0) begin
      fails++;
      $display("FAIL R1: done %b stateOut %h expected 0 and zero", done, stateOut);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R4 all-zero input gives all-zero output
    stateIn = '0; msgIn = '0; roundIdx = 4'd0;
    runCase("R4 zero");

    // R7 R8: every round index with a single live message word
    for (int r = 0; r < 16; r++) begin
      for (int k = 0; k < 16; k++) begin
        for (int i = 0; i < 16; i++) stateIn[64*i +: 64] = nextRand();
        msgIn = '0;
        msgIn[64*k +: 64] = nextRand() | 64'h1;
        roundIdx = 4'(r);
        runCase("R7 R8 one-hot msg");
      end
    end

    // R5 R6 dense random messages and states
    for (int n = 0; n < 32; n++) begin
      for (int i = 0; i < 16; i++) begin
        stateIn[64*i +: 64] = nextRand();
        msgIn[64*i +: 64] = nextRand();
      end
      roundIdx = 4'(n % 12);
      runCase("R5 R6 dense");
    end

    // R9 wrapping additions: all-ones state and message
    stateIn = '1; msgIn = '1; roundIdx = 4'd11;
    runCase("R9 wrap");
    stateIn = '1; msgIn = '0; roundIdx = 4'd10;
    runCase("R9 wrap r10");

    // R1 reset again clears the output
    rstN = 1'b0;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || stateOut !== '0) begin
      fails++;
      $display("FAIL R1 re-reset: done %b stateOut %h expected 0 and zero", done, stateOut);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule